// File: doc/BRIEF.md
# SPI Host Transfer Sequencer

This block is an SPI host engine that moves one character at a time. Software-facing logic writes a word into a transmit holding register. The engine moves it into a shifter, drives it out on MOSI with the most significant bit first, and captures MISO into a receive holding register. The serial clock follows SPI mode 0: it idles low, the engine samples on the rising edge and changes MOSI on the falling edge. The serial clock runs at the system clock divided by the parameter `CLK_DIV`.

A single active-low chip select frames the characters. A policy input decides when the chip select goes high again:
- when nothing new was written before the current character ended;
- on an explicit last-transfer strobe;
- after every character.

Two delays are programmable: a gap after each character, which comes before any release, and a minimum high time on the chip select. An optional read-wait mode stops a new character from starting while received data is still unread.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `tx_empty` is 1, and both `rx_ready` and `overrun` are 0.
- R2: `cfg_nbits` = 0 gives 8-bit characters and `cfg_nbits` = 8 gives 16-bit characters. Each character has exactly that many `sck` rising edges, MSB first. In 8-bit mode the character is bits 7:0 of `tx_data`, and `rx_data` returns the received bits in 7:0 with zeros in bits 15:8.
- R3: `tx_empty` drops on the cycle after a `tx_wr` and rises again once the word has been moved into the shifter. `sck` toggles only while `cs_n` is 0.
- R4: With `cfg_cs_policy` = 0, the chip select stays low into the next character if a new word was written before the current character ended. Otherwise it goes high after the character.
- R5: With `cfg_cs_policy` = 1, the chip select stays low between characters, even while no data is waiting. It goes high only after the character that was held in the transmit register when `last_xfer` was pulsed has been shifted out. A pulse while the register is empty tags the next word written.
- R6: With `cfg_cs_policy` = 2, and also for the unused value 3, the chip select goes high after every character.
- R7: After each character the engine waits `cfg_bct_dly`×32 cycles before it releases the chip select or starts the next character. With `CLK_DIV` = 4 and 8-bit characters, a lone character holds `cs_n` low for 33 cycles when the delay is 0, and for 65 cycles when the delay is 1.
- R8: Once the chip select is high, it stays high for max(`cfg_cs_idle`, 1) cycles before it goes low again. The high time is exactly this value when data is already waiting.
- R9: With `cfg_rd_wait` = 1, no character starts while `rx_ready` is 1.
- R10: Each finished character loads `rx_data` and sets `rx_ready`. Finishing while `rx_ready` is still 1 and `cfg_rd_wait` = 0 sets `overrun`. An `rx_rd` pulse clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nbits | input | 4 | Character length code: 0 = 8 bits, 8 = 16 bits |
| cfg_cs_policy | input | 2 | Chip-select release policy |
| cfg_bct_dly | input | 8 | Gap after each character, in units of 32 cycles |
| cfg_cs_idle | input | 8 | Minimum chip-select high time in cycles |
| cfg_rd_wait | input | 1 | Stall new characters while receive data is unread |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 16 | Transmit word |
| last_xfer | input | 1 | Marks the pending word as the last of a frame |
| rx_rd | input | 1 | Read strobe for the receive holding register |
| rx_data | output | 16 | Receive holding register |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_ready | output | 1 | Unread receive data is present |
| overrun | output | 1 | A character was lost before it was read |
| sck | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The assertions take two things for granted:
- The configuration inputs change only while the engine is idle with the chip select high.
- `cfg_nbits` is only ever 0 or 8.

The bench keeps to both. It writes configuration only between scenarios, after the last character has ended and the chip select has gone high. It writes new words only when `tx_empty` shows the register is free. MISO is looped back inverted from MOSI, so every received value follows directly from the word that was sent.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2,
    ST_HOLD  = 2'd3
  } seq_st_e;

  typedef enum logic [1:0] {
    REL_NORELOAD = 2'd0,
    REL_LASTCMD  = 2'd1,
    REL_EACH     = 2'd2,
    REL_RSVD     = 2'd3
  } rel_pol_e;
endpackage

// File: rtl/spi_seq_dcnt.sv
module spi_seq_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         en,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)                   cnt_n = ld_val;
    else if (en && cnt_q != '0) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi_seq_shift.sv
module spi_seq_shift #(
  parameter int DW      = 16,
  parameter int CLK_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          len_full,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          done,
  output logic [DW-1:0] rx_word
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HCW  = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW  = $clog2(DW);
  localparam int HB   = DW / 2;

  logic           busy_q, busy_n;
  logic           sck_q, sck_n;
  logic           done_q, done_n;
  logic [HCW-1:0] hcnt_q, hcnt_n;
  logic [BCW-1:0] bit_q, bit_n;
  logic [DW-1:0]  sreg_q, sreg_n;
  logic [DW-1:0]  rreg_q, rreg_n;

  always_comb begin
    busy_n = busy_q;
    sck_n  = sck_q;
    hcnt_n = hcnt_q;
    bit_n  = bit_q;
    sreg_n = sreg_q;
    rreg_n = rreg_q;
    done_n = 1'b0;
    if (load) begin
      busy_n = 1'b1;
      sck_n  = 1'b0;
      hcnt_n = '0;
      bit_n  = len_full ? BCW'(DW - 1) : BCW'(HB - 1);
      sreg_n = len_full ? tx_word : {tx_word[HB-1:0], {HB{1'b0}}};
    end else if (busy_q) begin
      if (hcnt_q == HCW'(HALF - 1)) begin
        hcnt_n = '0;
        if (!sck_q) begin
          sck_n  = 1'b1;
          rreg_n = {rreg_q[DW-2:0], miso};
        end else begin
          sck_n = 1'b0;
          if (bit_q == '0) begin
            busy_n = 1'b0;
            done_n = 1'b1;
          end else begin
            bit_n  = bit_q - 1'b1;
            sreg_n = {sreg_q[DW-2:0], 1'b0};
          end
        end
      end else begin
        hcnt_n = hcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      hcnt_q <= '0;
      bit_q  <= '0;
      sreg_q <= '0;
      rreg_q <= '0;
    end else begin
      busy_q <= busy_n;
      sck_q  <= sck_n;
      done_q <= done_n;
      hcnt_q <= hcnt_n;
      bit_q  <= bit_n;
      sreg_q <= sreg_n;
      rreg_q <= rreg_n;
    end
  end

  assign sck     = sck_q;
  assign mosi    = sreg_q[DW-1];
  assign done    = done_q;
  assign rx_word = len_full ? rreg_q : {{HB{1'b0}}, rreg_q[HB-1:0]};

  // R2: the sequencer never restarts a character in flight
  a_r2_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int DW      = 16,
  parameter int CLK_DIV = 4,
  parameter int DLYW    = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      cfg_nbits,
  input  logic [1:0]      cfg_cs_policy,
  input  logic [DLYW-1:0] cfg_bct_dly,
  input  logic [DLYW-1:0] cfg_cs_idle,
  input  logic            cfg_rd_wait,
  input  logic            tx_wr,
  input  logic [DW-1:0]   tx_data,
  input  logic            last_xfer,
  input  logic            rx_rd,
  output logic [DW-1:0]   rx_data,
  output logic            tx_empty,
  output logic            rx_ready,
  output logic            overrun,
  output logic            sck,
  output logic            mosi,
  input  logic            miso,
  output logic            cs_n
);
  localparam int GW = DLYW + 5;

  seq_st_e       st_q, st_n;
  rel_pol_e      pol;
  logic          tx_full_q, tx_full_n;
  logic [DW-1:0] hold_q, hold_n;
  logic          tag_q, tag_n, shlast_q, shlast_n;
  logic          keep_q, keep_n, keep_now;
  logic          cs_q, cs_n_nx;
  logic [DW-1:0] rx_q, rx_n;
  logic          rdy_q, rdy_n, ovr_q, ovr_n;
  logic          len_full, start_ok, sh_load, sh_done, fin, release_cs;
  logic          guard_zero, gap_zero, gap_load;
  logic [DW-1:0] sh_rx;
  logic [DLYW-1:0] idle_val;
  logic [GW-1:0]   gap_val;

  assign len_full = (cfg_nbits == 4'd8);
  assign pol      = rel_pol_e'(cfg_cs_policy);
  assign start_ok = tx_full_q && !(cfg_rd_wait && rdy_q);
  assign idle_val = (cfg_cs_idle == '0) ? '0 : cfg_cs_idle - 1'b1;
  assign gap_val  = {cfg_bct_dly, 5'b0} - 1'b1;
  assign gap_load = sh_done && (cfg_bct_dly != '0);
  assign keep_now = (st_q == ST_SHIFT) ? tx_full_q : keep_q;

  always_comb begin
    case (pol)
      REL_NORELOAD: release_cs = !keep_now;
      REL_LASTCMD:  release_cs = shlast_q;
      default:      release_cs = 1'b1;
    endcase
  end

  always_comb begin
    st_n    = st_q;
    sh_load = 1'b0;
    fin     = 1'b0;
    case (st_q)
      ST_IDLE: if (start_ok && guard_zero) begin
        sh_load = 1'b1;
        st_n    = ST_SHIFT;
      end
      ST_SHIFT: if (sh_done) begin
        if (cfg_bct_dly == '0) begin
          fin  = 1'b1;
          st_n = release_cs ? ST_IDLE : ST_HOLD;
        end else begin
          st_n = ST_GAP;
        end
      end
      ST_GAP: if (gap_zero) begin
        fin  = 1'b1;
        st_n = release_cs ? ST_IDLE : ST_HOLD;
      end
      default: if (start_ok) begin
        sh_load = 1'b1;
        st_n    = ST_SHIFT;
      end
    endcase
  end

  always_comb begin
    tx_full_n = tx_wr ? 1'b1 : (sh_load ? 1'b0 : tx_full_q);
    hold_n    = tx_wr ? tx_data : hold_q;
    tag_n     = last_xfer ? 1'b1 : (sh_load ? 1'b0 : tag_q);
    shlast_n  = sh_load ? tag_q : shlast_q;
    keep_n    = sh_done ? tx_full_q : keep_q;
    cs_n_nx   = sh_load ? 1'b0 : ((fin && release_cs) ? 1'b1 : cs_q);
    rx_n      = sh_done ? sh_rx : rx_q;
    rdy_n     = sh_done ? 1'b1 : (rx_rd ? 1'b0 : rdy_q);
    ovr_n     = (sh_done && rdy_q && !rx_rd && !cfg_rd_wait) ? 1'b1
              : (rx_rd ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      tx_full_q <= 1'b0;
      hold_q    <= '0;
      tag_q     <= 1'b0;
      shlast_q  <= 1'b0;
      keep_q    <= 1'b0;
      cs_q      <= 1'b1;
      rx_q      <= '0;
      rdy_q     <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      st_q      <= st_n;
      tx_full_q <= tx_full_n;
      hold_q    <= hold_n;
      tag_q     <= tag_n;
      shlast_q  <= shlast_n;
      keep_q    <= keep_n;
      cs_q      <= cs_n_nx;
      rx_q      <= rx_n;
      rdy_q     <= rdy_n;
      ovr_q     <= ovr_n;
    end
  end

  spi_seq_shift #(.DW(DW), .CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .len_full(len_full),
    .tx_word(hold_q), .miso(miso), .sck(sck), .mosi(mosi),
    .done(sh_done), .rx_word(sh_rx)
  );

  spi_seq_dcnt #(.W(DLYW)) u_guard (
    .clk(clk), .rst_n(rst_n), .load(fin && release_cs), .ld_val(idle_val),
    .en(st_q == ST_IDLE), .zero(guard_zero)
  );

  spi_seq_dcnt #(.W(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(gap_load), .ld_val(gap_val),
    .en(st_q == ST_GAP), .zero(gap_zero)
  );

  assign rx_data  = rx_q;
  assign tx_empty = !tx_full_q;
  assign rx_ready = rdy_q;
  assign overrun  = ovr_q;
  assign cs_n     = cs_q;

  // R3: serial clock pulses only inside a selected frame
  a_r3_sck_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  // R3: a word taken by the shifter frees the holding register
  a_r3_tx_freed: assert property (@(posedge clk) disable iff (!rst_n)
    sh_load |=> (tx_empty || $past(tx_wr)));
  // R6: every-character policy always raises the chip select
  a_r6_each_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && cfg_cs_policy[1]) |=> cs_n);
  // R8: no start while the idle guard is still running
  a_r8_guard_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !guard_zero |-> !sh_load);
  // R9: read-wait blocks starts while data is unread
  a_r9_rd_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_wait && rx_ready) |-> !sh_load);
  // R10: overrun only rises on top of unread data
  a_r10_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_ready));
endmodule

// File: tb/tb_spi_xfer_seq.sv
module tb_spi_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_nbits;
  logic [1:0]  cfg_cs_policy;
  logic [7:0]  cfg_bct_dly, cfg_cs_idle;
  logic        cfg_rd_wait;
  logic        tx_wr, last_xfer, rx_rd;
  logic [15:0] tx_data, rx_data;
  logic        tx_empty, rx_ready, overrun, sck, mosi, miso, cs_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cs_falls = 0, sck_rises = 0;
  int run_len = 0, last_low = 0, last_high = 0;
  logic cs_prev = 1'b1, sck_prev = 1'b0;

  always #5 clk = ~clk;
  assign miso = ~mosi;

  spi_xfer_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_nbits(cfg_nbits), .cfg_cs_policy(cfg_cs_policy),
    .cfg_bct_dly(cfg_bct_dly), .cfg_cs_idle(cfg_cs_idle), .cfg_rd_wait(cfg_rd_wait),
    .tx_wr(tx_wr), .tx_data(tx_data), .last_xfer(last_xfer), .rx_rd(rx_rd),
    .rx_data(rx_data), .tx_empty(tx_empty), .rx_ready(rx_ready), .overrun(overrun),
    .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (cs_n !== cs_prev) begin
        if (cs_prev) begin last_high = run_len; cs_falls++; end
        else last_low = run_len;
        run_len = 1;
      end else run_len++;
      if (sck && !sck_prev) sck_rises++;
    end
    cs_prev  = cs_n;
    sck_prev = sck;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic wait_empty();
    while (!tx_empty) @(negedge clk);
  endtask

  task automatic wait_rx();
    while (!rx_ready) @(negedge clk);
  endtask

  task automatic rd(output logic [15:0] v);
    @(negedge clk); v = rx_data; rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic cfg(input logic [3:0] nb, input logic [1:0] pol, input logic [7:0] bct,
                     input logic [7:0] idl, input logic rw);
    @(negedge clk);
    cfg_nbits = nb; cfg_cs_policy = pol; cfg_bct_dly = bct;
    cfg_cs_idle = idl; cfg_rd_wait = rw;
  endtask

  task automatic t_reset();
    chk("R1 cs_n", cs_n, 1); chk("R1 sck", sck, 0); chk("R1 tx_empty", tx_empty, 1);
    chk("R1 rx_ready", rx_ready, 0); chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_len8();
    logic [15:0] v; int s0;
    cfg(4'd0, 2'd2, 8'd0, 8'd0, 1'b0);
    s0 = sck_rises;
    @(negedge clk); tx_wr = 1'b1; tx_data = 16'hBEA5;
    @(negedge clk); tx_wr = 1'b0;
    chk("R3 tx_empty after write", tx_empty, 0);
    @(negedge clk);
    chk("R3 tx_empty after load", tx_empty, 1);
    chk("R3 cs low", cs_n, 0);
    wait_rx(); rd(v); idle(4);
    chk("R2 rx 8-bit", v, 16'h005A);
    chk("R2 sck count 8", sck_rises - s0, 8);
    chk("R7 low len dly0", last_low, 33);
  endtask

  task automatic t_len16();
    logic [15:0] v; int s0;
    cfg(4'd8, 2'd2, 8'd0, 8'd0, 1'b0);
    s0 = sck_rises;
    wr(16'h1234); wait_rx(); rd(v); idle(4);
    chk("R2 rx 16-bit", v, 16'hEDCB);
    chk("R2 sck count 16", sck_rises - s0, 16);
  endtask

  task automatic t_pol0_reload();
    logic [15:0] v; int f0;
    cfg(4'd0, 2'd0, 8'd0, 8'd0, 1'b0);
    f0 = cs_falls;
    wr(16'h0011); wait_empty(); wr(16'h0022);
    wait_rx(); rd(v); chk("R4 first rx", v, 16'h00EE);
    wait_rx(); rd(v); chk("R4 second rx", v, 16'h00DD);
    idle(4);
    chk("R4 one frame on reload", cs_falls - f0, 1);
    chk("R4 release without reload", cs_n, 1);
  endtask

  task automatic t_pol0_noreload();
    logic [15:0] v; int f0;
    cfg(4'd0, 2'd0, 8'd0, 8'd0, 1'b0);
    f0 = cs_falls;
    wr(16'h0033); wait_rx(); rd(v);
    wr(16'h0044); wait_rx(); rd(v); idle(4);
    chk("R4 two frames no reload", cs_falls - f0, 2);
  endtask

  task automatic t_pol1();
    logic [15:0] v; int f0;
    cfg(4'd0, 2'd1, 8'd0, 8'd0, 1'b0);
    f0 = cs_falls;
    wr(16'h0055); wait_rx(); rd(v); idle(40);
    chk("R5 held low while waiting", cs_n, 0);
    @(negedge clk); tx_wr = 1'b1; tx_data = 16'h0066; last_xfer = 1'b1;
    @(negedge clk); tx_wr = 1'b0; last_xfer = 1'b0;
    wait_rx(); rd(v); idle(4);
    chk("R5 last rx", v, 16'h0099);
    chk("R5 released after last", cs_n, 1);
    chk("R5 single frame", cs_falls - f0, 1);
  endtask

  task automatic t_each(input logic [1:0] pol, input string tag);
    logic [15:0] v; int f0;
    cfg(4'd0, pol, 8'd0, 8'd0, 1'b0);
    f0 = cs_falls;
    wr(16'h0077); wait_empty(); wr(16'h0088);
    wait_rx(); rd(v); wait_rx(); rd(v); idle(4);
    chk(tag, cs_falls - f0, 2);
    chk("R8 min high dly0", last_high, 1);
  endtask

  task automatic t_idle_guard();
    logic [15:0] v;
    cfg(4'd0, 2'd2, 8'd0, 8'd10, 1'b0);
    wr(16'h00A1); wait_empty(); wr(16'h00B2);
    wait_rx(); rd(v); wait_rx(); rd(v); idle(4);
    chk("R8 cs high time 10", last_high, 10);
  endtask

  task automatic t_gap();
    logic [15:0] v;
    cfg(4'd0, 2'd2, 8'd1, 8'd0, 1'b0);
    wr(16'h00C3); wait_rx(); rd(v); idle(40);
    chk("R7 low len dly1", last_low, 65);
    chk("R7 rx", v, 16'h003C);
  endtask

  task automatic t_rd_wait();
    logic [15:0] v;
    cfg(4'd0, 2'd2, 8'd0, 8'd0, 1'b1);
    wr(16'h0012); wait_empty(); wr(16'h0034);
    wait_rx(); idle(150);
    chk("R9 stalled tx", tx_empty, 0);
    chk("R9 rx kept", rx_data, 16'h00ED);
    chk("R9 no overrun", overrun, 0);
    rd(v); wait_rx(); rd(v);
    chk("R9 second after read", v, 16'h00CB);
  endtask

  task automatic t_overrun();
    logic [15:0] v;
    cfg(4'd0, 2'd2, 8'd0, 8'd0, 1'b0);
    wr(16'h0056); wait_empty(); wr(16'h0078); idle(120);
    chk("R10 overrun set", overrun, 1);
    chk("R10 newest rx", rx_data, 16'h0087);
    rd(v);
    chk("R10 ready cleared", rx_ready, 0);
    chk("R10 overrun cleared", overrun, 0);
  endtask

  initial begin
    rst_n = 1'b0; tx_wr = 1'b0; tx_data = '0; last_xfer = 1'b0; rx_rd = 1'b0;
    cfg_nbits = '0; cfg_cs_policy = '0; cfg_bct_dly = '0; cfg_cs_idle = '0; cfg_rd_wait = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_len8();
    t_len16();
    t_pol0_reload();
    t_pol0_noreload();
    t_pol1();
    t_each(2'd2, "R6 policy 2 frames");
    t_each(2'd3, "R6 policy 3 frames");
    t_idle_guard();
    t_gap();
    t_rd_wait();
    t_overrun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule